// File: doc/BRIEF.md
# Paper Tape Binary Loader

This block turns a stream of 8-bit tape characters into memory write commands. A tape reader hands it characters over a valid/ready handshake. The block rebuilds 12-bit words from pairs of 6-bit slices, and each word is either a new load address or a data word to store. It emits a 15-bit write address, made of a 3-bit field and a 12-bit address, together with 12-bit write data and a one-cycle write strobe. The block tells characters apart by their top two bits.

The block also handles the framing characters on the tape:
- Leader characters before the first word are skipped.
- Erase characters bracket stretches of tape that are to be ignored.
- Field-change characters select the upper address bits.

The first leader-class character after the words have begun ends the load. The word pair just before it is never stored. That pair is the checksum, and it is compared with the 12-bit running sum of the raw character values of all the pairs that were taken.

A start pulse clears the block and begins a load. When the load ends, the block raises done, along with sumOk when the checksum matches. It then stops accepting characters until the next start pulse. Because any pair might turn out to be the checksum, each complete pair is held back. It is acted on only when the next address or data character shows that more words follow.

Top module: `tape_bin_loader`

## Requirements
- R1: After reset the block is idle: chReady, done, sumOk and wrEn are low. A start pulse clears done, sumOk, the field (to 0), the current address (to 0), the running sum and any held pair, and raises chReady from the next cycle.
- R2: A word is built from two accepted characters as {first[5:0], second[5:0]}. A first character 01xxxxxx marks an address pair and 00xxxxxx marks a data pair. The character after such a first character is always taken as the second of the pair, whatever its upper bits.
- R3: A data pair is written to address {field, current address}, after which the current address increments modulo 4096. An address pair replaces the current address and writes nothing.
- R4: A pair is acted on in the cycle after the next address or data first character is accepted. wrEn is a single-cycle pulse and is never high two cycles in a row.
- R5: A first-position character equal to 8'hFF starts an erased stretch. Every character up to and including the next 8'hFF is ignored: no write, no field change and no checksum contribution.
- R6: A first-position character 10xxxxxx seen before any complete pair is leader and is ignored.
- R7: A first-position character 10xxxxxx seen after a complete pair ends the load. From the next cycle done is high, chReady is low, and the held pair is never written.
- R8: A first-position character 11fffxxx other than 8'hFF sets the field to fff (bits 5:3). This applies to pairs whose first character arrives later, and the character adds nothing to the checksum.
- R9: The running sum is the 12-bit sum of the raw 8-bit values of both characters of every pair that was acted on. At the end, sumOk is high exactly when the running sum minus the held pair's word is 0 modulo 4096.
- R10: done and sumOk keep their values, and no write occurs, until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that clears the block and begins a load |
| chValid | input | 1 | Reader offers a character |
| chData | input | 8 | Tape character |
| chReady | output | 1 | Block accepts a character this cycle |
| wrEn | output | 1 | Write strobe, one cycle |
| wrAddr | output | 15 | Write address, field in bits 14:12 |
| wrData | output | 12 | Write data |
| done | output | 1 | Load has ended at the trailer |
| sumOk | output | 1 | Checksum matched; valid while done is high |

## Verification
The bench drives whole tapes of several kinds:
- A plain tape with leader, one address and a few data words shows that leader is skipped and that pairs are written one pair late.
- A tape with an erased stretch containing address, data and field-change characters, followed by a real field change, separates discarded characters from those that take effect.
- A tape whose address runs past 7777 octal, with a second character carrying set class bits, checks the wrap of the address and the raw use of the second character.
- A long tape of large characters takes the checksum past 4096.
- A tape with a deliberately wrong checksum, a load that is restarted with a pair still held, and characters offered after done separate a correct comparison from one that always passes, and show that held state is discarded.

// File: rtl/tape_loader_pkg.sv
package tape_loader_pkg;

  // Control states of the character sequencer
  typedef enum logic [1:0] {
    S_IDLE,
    S_FIRST,
    S_SECOND,
    S_SKIP
  } ldState_t;

  // Strobes passed from control to datapath, all single-cycle
  typedef struct packed {
    logic clrAll;     // start of a new load
    logic takeFirst;  // capture first character of an address/data pair
    logic commit;     // act on the held pair (same edge as takeFirst)
    logic takeSecond; // complete the pair and hold it
    logic setField;   // field-change character
    logic finish;     // trailer seen: evaluate checksum, end load
  } ldCtrl_t;

endpackage

// File: rtl/tape_loader_ctrl.sv
module tape_loader_ctrl
  import tape_loader_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              chValid,
  input  logic [CHAR_W-1:0] chData,
  input  logic              pendValid,
  output logic              chReady,
  output ldCtrl_t           ctl
);

  localparam logic [1:0] CLS_DATA    = 2'b00;
  localparam logic [1:0] CLS_ADDR    = 2'b01;
  localparam logic [1:0] CLS_LEADER  = 2'b10;
  localparam logic [1:0] CLS_CONTROL = 2'b11;

  ldState_t state, stateNxt;
  logic     accept;
  logic     isErase;
  logic [1:0] chClass;

  assign chReady = (state != S_IDLE);
  assign accept  = chValid && chReady;
  assign isErase = &chData;
  assign chClass = chData[CHAR_W-1 -: 2];

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    if (start) begin
      ctl.clrAll = 1'b1;
      stateNxt   = S_FIRST;
    end else if (accept) begin
      unique case (state)
        S_FIRST: begin
          if (isErase) begin
            stateNxt = S_SKIP;
          end else begin
            unique case (chClass)
              CLS_CONTROL: ctl.setField = 1'b1;
              CLS_LEADER: begin
                if (pendValid) begin
                  ctl.finish = 1'b1;
                  stateNxt   = S_IDLE;
                end
              end
              CLS_DATA, CLS_ADDR: begin
                ctl.takeFirst = 1'b1;
                ctl.commit    = pendValid;
                stateNxt      = S_SECOND;
              end
              default: ;
            endcase
          end
        end
        S_SECOND: begin
          ctl.takeSecond = 1'b1;
          stateNxt       = S_FIRST;
        end
        S_SKIP: begin
          if (isErase) stateNxt = S_FIRST;
        end
        default: stateNxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/tape_loader_dp.sv
module tape_loader_dp
  import tape_loader_pkg::*;
#(
  parameter int CHAR_W  = 8,
  parameter int SLICE_W = 6,
  parameter int FIELD_W = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ldCtrl_t                       ctl,
  input  logic [CHAR_W-1:0]             chData,
  output logic                          pendValid,
  output logic                          wrEn,
  output logic [FIELD_W+2*SLICE_W-1:0]  wrAddr,
  output logic [2*SLICE_W-1:0]          wrData,
  output logic                          done,
  output logic                          sumOk
);

  localparam int WORD_W = 2 * SLICE_W;
  localparam int ADDR_W = FIELD_W + WORD_W;

  logic [CHAR_W-1:0]  firstChar;
  logic [FIELD_W-1:0] field, firstField, pendField;
  logic [WORD_W-1:0]  curAddr, pendWord, pendSum, runSum;
  logic               pendIsAddr;
  logic [WORD_W-1:0]  pairWord, pairSum;

  // Word and raw character sum of the pair being completed
  assign pairWord = {firstChar[SLICE_W-1:0], chData[SLICE_W-1:0]};
  assign pairSum  = WORD_W'(firstChar) + WORD_W'(chData);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrAll) begin
      firstChar  <= '0;
      field      <= '0;
      firstField <= '0;
      pendField  <= '0;
      curAddr    <= '0;
      pendWord   <= '0;
      pendSum    <= '0;
      runSum     <= '0;
      pendIsAddr <= 1'b0;
      pendValid  <= 1'b0;
      wrEn       <= 1'b0;
      wrAddr     <= '0;
      wrData     <= '0;
      done       <= 1'b0;
      sumOk      <= 1'b0;
    end else begin
      wrEn <= 1'b0;
      if (ctl.setField) field <= chData[SLICE_W-1 -: FIELD_W];
      if (ctl.takeFirst) begin
        firstChar  <= chData;
        firstField <= field;
      end
      if (ctl.commit) begin
        pendValid <= 1'b0;
        runSum    <= runSum + pendSum;
        if (pendIsAddr) begin
          curAddr <= pendWord;
        end else begin
          wrEn    <= 1'b1;
          wrAddr  <= ADDR_W'({pendField, curAddr});
          wrData  <= pendWord;
          curAddr <= curAddr + WORD_W'(1);
        end
      end
      if (ctl.takeSecond) begin
        pendValid  <= 1'b1;
        pendIsAddr <= firstChar[CHAR_W-2];
        pendWord   <= pairWord;
        pendSum    <= pairSum;
        pendField  <= firstField;
      end
      if (ctl.finish) begin
        pendValid <= 1'b0;
        done      <= 1'b1;
        sumOk     <= ((runSum - pendWord) == '0);
      end
    end
  end

endmodule

// File: rtl/tape_bin_loader.sv
module tape_bin_loader
  import tape_loader_pkg::*;
#(
  parameter int CHAR_W  = 8,
  parameter int SLICE_W = 6,
  parameter int FIELD_W = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic                          chValid,
  input  logic [CHAR_W-1:0]             chData,
  output logic                          chReady,
  output logic                          wrEn,
  output logic [FIELD_W+2*SLICE_W-1:0]  wrAddr,
  output logic [2*SLICE_W-1:0]          wrData,
  output logic                          done,
  output logic                          sumOk
);

  ldCtrl_t ctl;
  logic    pendValid;

  tape_loader_ctrl #(.CHAR_W(CHAR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .chValid   (chValid),
    .chData    (chData),
    .pendValid (pendValid),
    .chReady   (chReady),
    .ctl       (ctl)
  );

  tape_loader_dp #(
    .CHAR_W  (CHAR_W),
    .SLICE_W (SLICE_W),
    .FIELD_W (FIELD_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .chData    (chData),
    .pendValid (pendValid),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .done      (done),
    .sumOk     (sumOk)
  );

endmodule

// File: rtl/tape_bin_loader_chk.sv
module tape_bin_loader_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic chReady,
  input logic wrEn,
  input logic done,
  input logic sumOk
);

  // R7: an ended load accepts nothing
  p_idle_when_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !chReady);

  // R7: no write is issued once the load has ended
  p_no_write_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrEn);

  // R4: write strobe lasts one cycle
  p_single_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R1: start clears the result and opens the reader handshake
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!done && !sumOk && chReady));

  // R9: checksum verdict only exists with done
  p_ok_needs_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    sumOk |-> done);

  // R10: result holds until the next start
  p_done_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(sumOk)));

endmodule

bind tape_bin_loader tape_bin_loader_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .chReady (chReady),
  .wrEn    (wrEn),
  .done    (done),
  .sumOk   (sumOk)
);

// File: tb/tape_bin_loader_bench.sv
module tape_bin_loader_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        chValid = 1'b0;
  logic [7:0]  chData = '0;
  logic        chReady, wrEn, done, sumOk;
  logic [14:0] wrAddr;
  logic [11:0] wrData;

  int nChecks = 0;
  int nErrors = 0;

  logic [26:0] expQ[$];
  logic [11:0] tbSum;
  logic [11:0] tbAddr;
  logic [2:0]  tbField;

  always #(CLK_PERIOD/2) clk = ~clk;

  tape_bin_loader u_tape_bin_loader (
    .clk(clk), .rstN(rstN), .start(start), .chValid(chValid), .chData(chData),
    .chReady(chReady), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .done(done), .sumOk(sumOk)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0o expected %0o", tag, act, exp);
    end
  endtask

  // Monitor: compare every write against the scoreboard queue (R3, R4)
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nErrors++;
        $display("FAIL R3 unexpected write: actual %0o:%0o expected none", wrAddr, wrData);
      end else begin
        logic [26:0] e;
        e = expQ.pop_front();
        if ({wrAddr, wrData} != e) begin
          nErrors++;
          $display("FAIL R3 write: actual %0o:%0o expected %0o:%0o",
                   wrAddr, wrData, e[26:12], e[11:0]);
        end
      end
    end
  end

  task automatic sendChar(input logic [7:0] c);
    @(negedge clk);
    chValid = 1'b1;
    chData  = c;
    @(posedge clk);
    #1;
    chValid = 1'b0;
  endtask

  task automatic beginTape();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1;
    start   = 1'b0;
    tbSum   = '0;
    tbAddr  = '0;
    tbField = '0;
  endtask

  // Driver: pair sent and expected effect pushed to the scoreboard
  task automatic sendRawPair(input logic [7:0] c1, input logic [7:0] c2);
    logic [11:0] w;
    w = {c1[5:0], c2[5:0]};
    sendChar(c1);
    sendChar(c2);
    tbSum = tbSum + 12'(c1) + 12'(c2);
    if (c1[6]) tbAddr = w;
    else begin
      expQ.push_back({tbField, tbAddr, w});
      tbAddr = tbAddr + 12'd1;
    end
  endtask

  task automatic sendPair(input logic isAddr, input logic [11:0] w);
    sendRawPair({1'b0, isAddr, w[11:6]}, {2'b00, w[5:0]});
  endtask

  task automatic sendField(input logic [2:0] f);
    sendChar({2'b11, f, 3'b000});
    tbField = f;
  endtask

  task automatic endTape(input logic [11:0] delta);
    logic [11:0] w;
    w = tbSum + delta;
    sendChar({2'b00, w[11:6]});
    sendChar({2'b00, w[5:0]});
    sendChar(8'o200);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 reset chReady", chReady, 0);
    check("R1 reset done", done, 0);
    check("R1 reset wrEn", wrEn, 0);

    // Plain tape
    beginTape();
    @(negedge clk);
    check("R1 chReady after start", chReady, 1);
    repeat (3) sendChar(8'o200);
    @(negedge clk);
    check("R6 leader ignored", done, 0);
    sendPair(1'b1, 12'o1234);
    sendPair(1'b0, 12'o5533);
    @(negedge clk);
    check("R4 pair held back", wrEn, 0);
    sendPair(1'b0, 12'o0001);
    endTape(12'd0);
    check("R7 done", done, 1);
    check("R9 sumOk good", sumOk, 1);
    check("R7 chReady low", chReady, 0);
    check("R7 checksum pair not stored", expQ.size(), 0);

    // Erase and field change
    beginTape();
    sendPair(1'b1, 12'o0100);
    sendPair(1'b0, 12'o1111);
    sendChar(8'hFF);
    sendChar(8'o102); sendChar(8'o005); sendChar(8'o330);
    sendChar(8'o123); sendChar(8'o200);
    sendChar(8'hFF);
    @(negedge clk);
    check("R5 erased leader did not end", done, 0);
    sendPair(1'b0, 12'o2222);
    sendField(3'd5);
    sendPair(1'b0, 12'o3333);
    endTape(12'd0);
    check("R5 R8 sum excludes erased and field", sumOk, 1);
    check("R8 queue drained", expQ.size(), 0);

    // Address wrap and raw second character
    beginTape();
    sendField(3'd2);
    sendPair(1'b1, 12'o7777);
    sendPair(1'b0, 12'o4321);
    sendPair(1'b0, 12'o1234);
    sendRawPair(8'o025, 8'o345);
    endTape(12'd0);
    check("R2 raw second char in sum", sumOk, 1);
    check("R3 wrap queue drained", expQ.size(), 0);

    // Bad checksum, then hold after done
    beginTape();
    sendPair(1'b1, 12'o0010);
    sendPair(1'b0, 12'o0707);
    endTape(12'd1);
    check("R7 done bad tape", done, 1);
    check("R9 sumOk bad", sumOk, 0);
    sendChar(8'o000); sendChar(8'o011); sendChar(8'o001); sendChar(8'o002);
    @(negedge clk);
    check("R10 done held", done, 1);
    check("R10 sumOk held", sumOk, 0);

    // Restart with a pair held
    beginTape();
    @(negedge clk);
    check("R1 start clears done", done, 0);
    check("R1 start clears sumOk", sumOk, 0);
    sendPair(1'b1, 12'o0500);
    sendChar(8'o000); sendChar(8'o077);
    beginTape();
    sendPair(1'b1, 12'o0600);
    sendPair(1'b0, 12'o0042);
    endTape(12'd0);
    check("R1 restart sum cleared", sumOk, 1);
    check("R1 held pair discarded", expQ.size(), 0);

    // Long tape, sum wraps past 4096
    beginTape();
    sendPair(1'b1, 12'o2000);
    for (int i = 0; i < 50; i++) sendPair(1'b0, {6'o77, 6'(i)});
    endTape(12'd0);
    check("R9 wrapped sum ok", sumOk, 1);
    check("R9 long queue drained", expQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule